// File: doc/BRIEF.md
# Partitioned Throttle Combiner with Change Log

This block is one node of a throttle network. Each of its source inputs is raised by a downstream buffer that is close to full, before that buffer can overflow. The node merges these requests into one throttle output per partition. A software-written routing table gives each source a target partition and an enable bit. Separate subsystems can therefore run as independent partitions, or be merged so that they throttle together, by rewriting the table.

Each source first passes through a two-flop synchronizer. A change logger compares the synchronized levels with the last level it recorded for each source. For every source that differs, it stores an entry holding a free-running 32-bit cycle stamp, the source index and the new level. Entries go into a circular history memory. Software reads that memory through a small register port to find out which buffers caused dead time and when. A freeze bit stops logging so the log can be read out intact. Any change missed while frozen sets a sticky overflow flag.

Top module: `throttle_fanin`

## Requirements
- R1: After reset, all partition outputs are 0. The status word reads 0 (no entries, write slot 0, no overflow). Every routing entry reads 0, which means the source is disabled.
- R2: A partition output is the OR of the enabled sources routed to it. A source change reaches the output on the third rising clock edge after the change. A routing write takes effect on the output one edge after the edge that wrote it.
- R3: A source whose routing enable (bit 31) is 0 has no effect on any partition output.
- R4: Each change of a synchronized source level writes exactly one history entry. The info word holds the source index in bits 15:0 and the new level in bit 16. The stamp words of two entries differ by the number of cycles between the two changes. Sources are logged whether or not they are enabled.
- R5: Changes on several sources in the same cycle are logged one per cycle, lowest source index first, with stamps that increase by 1.
- R6: The history is circular. Once more than DEPTH entries have been written, the oldest is overwritten. The entry count (status bits 15:8) stays at DEPTH, and the write slot (status bits 7:0) wraps modulo DEPTH.
- R7: While freeze (control bit 0) is 1, no entry is written and the write slot holds. Any source change sets overflow (status bit 31). Changes that happened while frozen are not logged after unfreezing.
- R8: Writing control with bit 1 set clears the entry count, the write slot and the overflow flag.
- R9: Register reads return data one cycle after the address is presented. Routing entries are at addresses 0..N_SRC-1, with the partition in the low bits and enable in bit 31. Control is at 0x40 and status at 0x41. History slot i has its stamp at 0x80+2i and its info word at 0x81+2i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_thr_i | input | N_SRC | Asynchronous throttle requests, one per source |
| part_thr_o | output | N_PART | Registered throttle output per partition |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Registered read data for the previous cycle's address |

## Verification
Routing is tested with single sources, with two sources sharing one partition, with a disabled source, and with a live remap of an active source. Together these separate OR merging, masking and routing-table timing. Logging is tested with one source toggling at a known interval, which confirms the stamp arithmetic. A three-source simultaneous rise shows the lowest-index-first order. A burst of twenty changes exposes wrap-around and count saturation. A change made under freeze exercises the overflow flag and shows that no stale entry is written after unfreezing.

// File: rtl/thr_pkg.sv
package thr_pkg;
    localparam int TS_W = 32;
    localparam logic [7:0] ADDR_CTRL = 8'h40;
    localparam logic [7:0] ADDR_STAT = 8'h41;
    localparam logic [7:0] ADDR_HIST = 8'h80;

    typedef struct packed {
        logic [TS_W-1:0] ts;
        logic            lvl;
        logic [15:0]     src;
    } hist_entry_t;
endpackage

// File: rtl/thr_sync.sv
module thr_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    typedef struct packed {
        logic [W-1:0] s1;
        logic [W-1:0] s2;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d.s1 = async_i;
        st_d.s2 = st_q.s1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_o = st_q.s2;
endmodule

// File: rtl/thr_fanin.sv
module thr_fanin #(
    parameter int N_SRC  = 8,
    parameter int N_PART = 4,
    localparam int PW    = (N_PART > 1) ? $clog2(N_PART) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [N_SRC-1:0]           lvl_i,
    input  logic [N_SRC-1:0]           en_i,
    input  logic [N_SRC-1:0][PW-1:0]   part_i,
    output logic [N_PART-1:0]          thr_o
);
    logic [N_PART-1:0] thr_d, thr_q;

    for (genvar p = 0; p < N_PART; p++) begin : g_part
        always_comb begin
            thr_d[p] = 1'b0;
            for (int s = 0; s < N_SRC; s++) begin
                if (lvl_i[s] && en_i[s] && (part_i[s] == PW'(p)))
                    thr_d[p] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) thr_q <= '0;
        else        thr_q <= thr_d;
    end

    assign thr_o = thr_q;
endmodule

// File: rtl/thr_hist.sv
module thr_hist
    import thr_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int DEPTH  = 16,
    localparam int SIW   = (N_SRC > 1) ? $clog2(N_SRC) : 1,
    localparam int HAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = HAW + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_SRC-1:0] lvl_i,
    input  logic             freeze_i,
    input  logic             clear_i,
    output hist_entry_t      mem_o [DEPTH],
    output logic [HAW-1:0]   ptr_o,
    output logic [CW-1:0]    cnt_o,
    output logic             ovf_o
);
    typedef struct {
        logic [N_SRC-1:0] seen;
        logic [TS_W-1:0]  ts;
        logic [HAW-1:0]   ptr;
        logic [CW-1:0]    cnt;
        logic             ovf;
        hist_entry_t      mem [DEPTH];
    } hist_st_t;

    hist_st_t st_d, st_q;

    always_comb begin
        logic [N_SRC-1:0] diff;
        logic [SIW-1:0]   pick;
        logic             found;

        st_d    = st_q;
        st_d.ts = st_q.ts + 1'b1;
        diff    = lvl_i ^ st_q.seen;
        pick    = '0;
        found   = 1'b0;
        for (int i = N_SRC - 1; i >= 0; i--) begin
            if (diff[i]) begin
                pick  = SIW'(i);
                found = 1'b1;
            end
        end

        if (clear_i) begin
            st_d.ptr = '0;
            st_d.cnt = '0;
            st_d.ovf = 1'b0;
        end else if (freeze_i) begin
            st_d.seen = lvl_i;
            if (found) st_d.ovf = 1'b1;
        end else if (found) begin
            st_d.mem[st_q.ptr] = '{ts: st_q.ts, lvl: lvl_i[pick], src: 16'(pick)};
            st_d.seen[pick]    = lvl_i[pick];
            st_d.ptr = (st_q.ptr == HAW'(DEPTH - 1)) ? '0 : st_q.ptr + 1'b1;
            if (st_q.cnt != CW'(DEPTH)) st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.seen <= '0;
            st_q.ts   <= '0;
            st_q.ptr  <= '0;
            st_q.cnt  <= '0;
            st_q.ovf  <= 1'b0;
            for (int i = 0; i < DEPTH; i++) st_q.mem[i] <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mem_o = st_q.mem;
    assign ptr_o = st_q.ptr;
    assign cnt_o = st_q.cnt;
    assign ovf_o = st_q.ovf;
endmodule

// File: rtl/throttle_fanin.sv
module throttle_fanin
    import thr_pkg::*;
#(
    parameter int N_SRC  = 8,
    parameter int N_PART = 4,
    parameter int DEPTH  = 16,
    localparam int PW    = (N_PART > 1) ? $clog2(N_PART) : 1,
    localparam int HAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = HAW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_SRC-1:0]  src_thr_i,
    output logic [N_PART-1:0] part_thr_o,
    input  logic              reg_we,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata
);
    typedef struct packed {
        logic [N_SRC-1:0][PW-1:0] part;
        logic [N_SRC-1:0]         en;
        logic                     freeze;
        logic [31:0]              rdata;
    } regs_t;

    regs_t            st_d, st_q;
    logic [N_SRC-1:0] lvl_sync;
    logic             clear_pulse;
    logic             freeze_q;
    hist_entry_t      hmem [DEPTH];
    logic [HAW-1:0]   hist_ptr;
    logic [CW-1:0]    hist_cnt;
    logic             hist_ovf;

    thr_sync #(.W(N_SRC)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_i(src_thr_i), .sync_o(lvl_sync)
    );

    thr_fanin #(.N_SRC(N_SRC), .N_PART(N_PART)) u_fanin (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync), .en_i(st_q.en),
        .part_i(st_q.part), .thr_o(part_thr_o)
    );

    thr_hist #(.N_SRC(N_SRC), .DEPTH(DEPTH)) u_hist (
        .clk(clk), .rst_n(rst_n), .lvl_i(lvl_sync), .freeze_i(st_q.freeze),
        .clear_i(clear_pulse), .mem_o(hmem), .ptr_o(hist_ptr),
        .cnt_o(hist_cnt), .ovf_o(hist_ovf)
    );

    assign freeze_q    = st_q.freeze;
    assign clear_pulse = reg_we && (reg_addr == ADDR_CTRL) && reg_wdata[1];

    always_comb begin
        logic [7:0]  hoff;
        hist_entry_t he;

        st_d = st_q;
        if (reg_we) begin
            for (int s = 0; s < N_SRC; s++) begin
                if (reg_addr == 8'(s)) begin
                    st_d.part[s] = reg_wdata[PW-1:0];
                    st_d.en[s]   = reg_wdata[31];
                end
            end
            if (reg_addr == ADDR_CTRL) st_d.freeze = reg_wdata[0];
        end

        hoff = reg_addr - ADDR_HIST;
        he   = hmem[hoff[HAW:1]];
        st_d.rdata = '0;
        for (int s = 0; s < N_SRC; s++) begin
            if (reg_addr == 8'(s))
                st_d.rdata = {st_q.en[s], {(31 - PW){1'b0}}, st_q.part[s]};
        end
        if (reg_addr == ADDR_CTRL)
            st_d.rdata = {31'b0, st_q.freeze};
        else if (reg_addr == ADDR_STAT)
            st_d.rdata = {hist_ovf, 15'b0, 8'(hist_cnt), 8'(hist_ptr)};
        else if (reg_addr >= ADDR_HIST && hoff < 8'(2 * DEPTH))
            st_d.rdata = hoff[0] ? {15'b0, he.lvl, he.src} : he.ts;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign reg_rdata = st_q.rdata;
endmodule

// File: rtl/throttle_fanin_chk.sv
module throttle_fanin_chk #(
    parameter int N_SRC  = 8,
    parameter int N_PART = 4,
    parameter int DEPTH  = 16,
    localparam int HAW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = HAW + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic [N_SRC-1:0]  lvl_sync,
    input logic [N_PART-1:0] part_thr_o,
    input logic              freeze_q,
    input logic              clear_pulse,
    input logic [HAW-1:0]    hist_ptr,
    input logic [CW-1:0]     hist_cnt,
    input logic              hist_ovf
);
    // R2: an output can be high only if some synchronized source was high one cycle before
    assert_out_needs_src_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (part_thr_o != '0) |-> $past(lvl_sync != '0));

    // R6: entry count never exceeds the memory depth
    assert_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        hist_cnt <= CW'(DEPTH));

    // R4: the write slot only steps by one (with wrap) or returns to zero
    assert_ptr_step_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(hist_ptr) |-> (hist_ptr == '0) || (hist_ptr == HAW'($past(hist_ptr) + 1'b1)));

    // R7: while frozen and not cleared, the write slot holds
    assert_frozen_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (freeze_q && !clear_pulse) |=> $stable(hist_ptr));

    // R7: overflow only rises out of a frozen cycle
    assert_ovf_when_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(hist_ovf) |-> $past(freeze_q));

    // R8: a clear leaves count and overflow at zero
    assert_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        clear_pulse |=> (hist_cnt == '0) && !hist_ovf);
endmodule

bind throttle_fanin throttle_fanin_chk #(.N_SRC(N_SRC), .N_PART(N_PART), .DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .lvl_sync(lvl_sync), .part_thr_o(part_thr_o),
    .freeze_q(freeze_q), .clear_pulse(clear_pulse), .hist_ptr(hist_ptr),
    .hist_cnt(hist_cnt), .hist_ovf(hist_ovf)
);

// File: tb/throttle_fanin_test.sv
`timescale 1ns/1ps
module throttle_fanin_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  src = '0;
    logic [3:0]  part;
    logic        we = 1'b0;
    logic [7:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    localparam logic [7:0] CTRL = 8'h40;
    localparam logic [7:0] STAT = 8'h41;

    throttle_fanin #(.N_SRC(8), .N_PART(4), .DEPTH(16)) uut (
        .clk(clk), .rst_n(rst_n), .src_thr_i(src), .part_thr_o(part),
        .reg_we(we), .reg_addr(addr), .reg_wdata(wdata), .reg_rdata(rdata)
    );

    always #2 clk = ~clk;

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        we = 1'b1; addr = a; wdata = d;
        @(posedge clk); @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        addr = a;
        @(posedge clk); @(negedge clk);
        d = rdata;
    endtask

    task automatic quiet();
        src = '0;
        cyc(6);
        wr(CTRL, 32'h2);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 outputs", 32'(part), 0);
        rd(STAT, d); chk("R1 status", d, 0);
        rd(8'h00, d); chk("R1 map0", d, 0);
    endtask

    task automatic t_route();
        logic [31:0] d;
        wr(8'h00, 32'h8000_0000);
        wr(8'h01, 32'h8000_0000);
        wr(8'h02, 32'h8000_0002);
        wr(8'h03, 32'h0000_0001);
        rd(8'h02, d); chk("R9 map2 readback", d, 32'h8000_0002);
        src[2] = 1'b1;
        cyc(2); chk("R2 before third edge", 32'(part), 0);
        cyc(1); chk("R2 third edge", 32'(part), 32'h4);
        src[0] = 1'b1; src[1] = 1'b1;
        cyc(3); chk("R2 two sources one partition", 32'(part), 32'h5);
        src[0] = 1'b0;
        cyc(3); chk("R2 OR keeps partition high", 32'(part), 32'h5);
        src[1] = 1'b0;
        cyc(3); chk("R2 partition released", 32'(part), 32'h4);
        src[3] = 1'b1;
        cyc(4); chk("R3 disabled source ignored", 32'(part), 32'h4);
        wr(8'h03, 32'h8000_0001);
        chk("R2 map write not yet visible", 32'(part), 32'h4);
        cyc(1); chk("R3 enabled source now drives", 32'(part), 32'h6);
        wr(8'h02, 32'h8000_0003);
        cyc(1); chk("R2 remap moves source", 32'(part), 32'hA);
    endtask

    task automatic t_log();
        logic [31:0] t0, t1, d;
        quiet();
        src[5] = 1'b1; cyc(10);
        src[5] = 1'b0; cyc(6);
        rd(STAT, d); chk("R4 status two entries", d, 32'h0000_0202);
        rd(8'h81, d); chk("R4 entry0 info", d, 32'h0001_0005);
        rd(8'h83, d); chk("R4 entry1 info", d, 32'h0000_0005);
        rd(8'h80, t0); rd(8'h82, t1);
        chk("R4 stamp delta", t1 - t0, 10);
    endtask

    task automatic t_simul();
        logic [31:0] t0, t1, d;
        quiet();
        src[1] = 1'b1; src[4] = 1'b1; src[6] = 1'b1;
        cyc(8);
        rd(8'h81, d); chk("R5 first lowest index", d, 32'h0001_0001);
        rd(8'h83, d); chk("R5 second", d, 32'h0001_0004);
        rd(8'h85, d); chk("R5 third", d, 32'h0001_0006);
        rd(8'h80, t0); rd(8'h82, t1);
        chk("R5 consecutive stamps", t1 - t0, 1);
    endtask

    task automatic t_wrap();
        logic [31:0] t0, t4, d;
        quiet();
        for (int k = 0; k < 20; k++) begin
            src[7] = ~src[7];
            cyc(2);
        end
        cyc(4);
        rd(STAT, d); chk("R6 count saturates, slot wraps", d, 32'h0000_1004);
        rd(8'h81, d); chk("R6 slot0 overwritten", d, 32'h0001_0007);
        rd(8'h87, d); chk("R6 slot3 newest", d, 32'h0000_0007);
        rd(8'h80, t0); rd(8'h88, t4);
        chk("R6 oldest vs overwritten stamp", t0 - t4, 24);
    endtask

    task automatic t_freeze();
        logic [31:0] d;
        quiet();
        wr(CTRL, 32'h1);
        rd(CTRL, d); chk("R9 ctrl readback", d, 32'h1);
        src[0] = 1'b1; cyc(6);
        rd(STAT, d); chk("R7 frozen overflow, no entry", d, 32'h8000_0000);
        chk("R7 outputs unaffected by freeze", 32'(part[0]), 1);
        wr(CTRL, 32'h0); cyc(4);
        rd(STAT, d); chk("R7 no stale entry after unfreeze", d, 32'h8000_0000);
        src[0] = 1'b0; cyc(6);
        rd(STAT, d); chk("R7 logging resumes", d, 32'h8000_0101);
        rd(8'h81, d); chk("R7 resumed entry", d, 32'h0000_0000);
        wr(CTRL, 32'h2);
        rd(STAT, d); chk("R8 clear", d, 32'h0);
    endtask

    task automatic finish_run();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    endtask

    initial begin
        cyc(3);
        rst_n = 1'b1;
        cyc(1);
        t_reset();
        t_route();
        t_log();
        t_simul();
        t_wrap();
        t_freeze();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            finish_run();
        end
    end
endmodule